// File: doc/BRIEF.md
# Filter Chain Program Sequencer

This block runs a short stored program that orders the work of a shared FIR compute engine in a decimating filter chain. The program holds three kinds of instruction. A wait instruction stalls until enough input samples have arrived. A filter instruction starts the engine with its filter settings and then sends the engine's result to one of two places: the input of a later program step, or the chain output. A jump instruction loads the program counter.

A program usually has this shape: wait for N samples, where N is the decimation of the first stage; run one or more filter steps that feed each other; then jump back to step 0. The cost of one output is the sum of the engine cycles and the sequencer's own cycles. One cycle goes to each wait that is already satisfied, and one cycle to each jump. The highest input rate the chain can sustain is the clock rate divided by ceil(cycles per output / total decimation).

Input samples arrive on a valid/ready stream. A sample is accepted on a cycle where `in_valid` and `in_ready` are both high. `in_ready` drops only while the sample counter is full. A sender that sees `in_ready` low keeps its sample until `in_ready` rises again. Chain results leave on a valid/ready stream. `out_valid` stays high until the cycle in which `out_ready` is also high, and the program does not advance while it waits. The engine handshake, the routing strobe and the program memory port are plain control pins. The program memory is read combinationally at `pm_addr`.

Top module: `fchain_seq`

## Requirements
- R1: During and just after reset, `pm_addr` is 0 and `eng_start`, `route_valid` and `out_valid` are low. `in_ready` is high.
- R2: The sample counter rises by one for each accepted input. It saturates at 2^CNT_W-1: at that value `in_ready` is low, and offered samples are neither accepted nor counted.
- R3: An instruction word is 40 bits. The opcode is in bits [39:38]: 00 wait, 01 filter, 10 jump, 11 reserved. A wait holds `pm_addr` while the count is below its required count in bits [CNT_W-1:0]. Once the count reaches that value, the wait advances the program counter in one cycle.
- R4: A filter instruction raises `eng_start` for exactly one cycle, in the first cycle its word is addressed. `eng_cfg` carries word bits [32:0] from that cycle and holds them until done. No further start occurs before `eng_done`.
- R5: `eng_done` in a filter step whose bit 36 is 0 gives a one-cycle `route_valid`, with `route_step` equal to bits [35:33]. The program counter then advances on the next cycle.
- R6: `eng_done` in a filter step whose bit 36 is 1 raises `out_valid` from the next cycle. `out_valid` and `pm_addr` hold until `out_ready`, and the program counter then advances.
- R7: When bit 37 of a filter word is set, the sample counter clears when the step completes. An input accepted in that same cycle counts as 1.
- R8: A jump loads the program counter with bits [PC_W-1:0] in one cycle.
- R9: A reserved opcode advances the program counter by one and has no other effect.
- R10: `eng_done` has no effect unless a filter step is waiting for it.
- R11: The program counter wraps from 2^PC_W-1 to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input sample offered |
| in_ready | output | 1 | Sample counter can accept |
| pm_addr | output | PC_W | Program memory address (program counter) |
| pm_data | input | 40 | Instruction word at `pm_addr` |
| eng_start | output | 1 | One-cycle engine start |
| eng_cfg | output | 33 | Filter settings for the engine |
| eng_done | input | 1 | Engine finished the current step |
| route_valid | output | 1 | Result goes to another step's input |
| route_step | output | PC_W | Destination step of a routed result |
| out_valid | output | 1 | Chain output sample ready |
| out_ready | input | 1 | Chain output accepted |

## Verification
The assertions check on every cycle the properties that belong to a single step. These are: counter stepping and saturation, the one-cycle start pulse, a stable engine configuration while the engine is busy, the jump target, a wait holding the counter, the one-cycle route strobe followed by an advance, and the output hold under back-pressure. Some behaviours appear only over a whole program, and only the bench scenarios show them. These are: the sample count a wait needs after a counter clear, the order of routed and emitted results, the wrap of the program counter across every step, and the proof that a stray done pulse outside a filter step starts nothing and emits nothing.

// File: rtl/fcs_pkg.sv
package fcs_pkg;
  localparam int INSTR_W  = 40;
  localparam int OP_LSB   = 38;
  localparam int RST_BIT  = 37;
  localparam int OUT_BIT  = 36;
  localparam int DEST_LSB = 33;
  localparam int DEST_W   = 3;

  typedef enum logic [1:0] {
    OP_WAIT = 2'b00,
    OP_FIR  = 2'b01,
    OP_JUMP = 2'b10,
    OP_RSV  = 2'b11
  } op_e;

  typedef enum logic [1:0] {
    ST_RUN  = 2'b00,
    ST_BUSY = 2'b01,
    ST_EMIT = 2'b10
  } state_e;

  // Settings handed to the compute engine for one filter step.
  typedef struct packed {
    logic [1:0] sym;        // symmetry type
    logic       halfband;
    logic [6:0] taps;
    logic [3:0] decim;
    logic [2:0] blk_log2;   // data block size as a power of two
    logic [7:0] blk_start;
    logic [7:0] coef_start;
  } fir_cfg_t;

  localparam int CFG_W = $bits(fir_cfg_t);
endpackage

// File: rtl/fcs_decode.sv
module fcs_decode
  import fcs_pkg::*;
#(
  parameter int PC_W  = 3,
  parameter int CNT_W = 4
) (
  input  logic [INSTR_W-1:0] word,
  output op_e                op,
  output logic               rst_wait,
  output logic               to_out,
  output logic [PC_W-1:0]    dest,
  output logic [PC_W-1:0]    target,
  output logic [CNT_W-1:0]   need,
  output logic [CFG_W-1:0]   cfg
);
  logic [DEST_W-1:0] dest_field;

  always_comb begin
    op         = op_e'(word[OP_LSB +: 2]);
    rst_wait   = word[RST_BIT];
    to_out     = word[OUT_BIT];
    dest_field = word[DEST_LSB +: DEST_W];
    dest       = dest_field[PC_W-1:0];
    cfg        = word[CFG_W-1:0];
    target     = word[PC_W-1:0];
    need       = word[CNT_W-1:0];
  end
endmodule

// File: rtl/fcs_wait_ctr.sv
module fcs_wait_ctr #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic             clr,
  input  logic [CNT_W-1:0] need,
  output logic             met
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] CNT_ONE = {{(CNT_W-1){1'b0}}, 1'b1};

  logic [CNT_W-1:0] cnt;
  logic             fire;

  always_comb begin
    in_ready = (cnt != CNT_MAX);
    fire     = in_valid && in_ready;
    met      = (cnt >= need);
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      cnt <= '0;
    else if (clr)    cnt <= fire ? CNT_ONE : '0;
    else if (fire)   cnt <= cnt + CNT_ONE;
  end

  a_r2_count_step: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && !clr) |=> (cnt == $past(cnt) + CNT_ONE));
  a_r2_hold_full: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt == CNT_MAX && !clr) |=> (cnt == CNT_MAX));
  a_r7_clear: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (cnt <= CNT_ONE));
endmodule

// File: rtl/fcs_ctrl.sv
module fcs_ctrl
  import fcs_pkg::*;
#(
  parameter int PC_W = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  op_e             op,
  input  logic            met,
  input  logic            rst_wait,
  input  logic            to_out,
  input  logic [PC_W-1:0] dest,
  input  logic [PC_W-1:0] target,
  input  logic            eng_done,
  input  logic            out_ready,
  output logic [PC_W-1:0] pc,
  output logic            eng_start,
  output logic            busy,
  output logic            route_valid,
  output logic [PC_W-1:0] route_step,
  output logic            out_valid,
  output logic            wait_clr
);
  localparam logic [PC_W-1:0] PC_ONE = {{(PC_W-1){1'b0}}, 1'b1};

  state_e          st;
  logic [PC_W-1:0] pc_q;
  logic [PC_W-1:0] pc_inc;
  logic            ir_rst;
  logic            ir_out;
  logic [PC_W-1:0] ir_dest;
  logic            done_fire;

  always_comb begin
    pc          = pc_q;
    pc_inc      = pc_q + PC_ONE;
    eng_start   = (st == ST_RUN) && (op == OP_FIR);
    busy        = (st == ST_BUSY);
    done_fire   = busy && eng_done;
    route_valid = done_fire && !ir_out;
    route_step  = ir_dest;
    out_valid   = (st == ST_EMIT);
    wait_clr    = done_fire && ir_rst;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= ST_RUN;
      pc_q    <= '0;
      ir_rst  <= 1'b0;
      ir_out  <= 1'b0;
      ir_dest <= '0;
    end else begin
      unique case (st)
        ST_RUN: begin
          unique case (op)
            OP_WAIT: if (met) pc_q <= pc_inc;
            OP_FIR: begin
              st      <= ST_BUSY;
              ir_rst  <= rst_wait;
              ir_out  <= to_out;
              ir_dest <= dest;
            end
            OP_JUMP: pc_q <= target;
            OP_RSV:  pc_q <= pc_inc;
            default: pc_q <= pc_inc;
          endcase
        end
        ST_BUSY: begin
          if (eng_done) begin
            if (ir_out) st <= ST_EMIT;
            else begin
              st   <= ST_RUN;
              pc_q <= pc_inc;
            end
          end
        end
        ST_EMIT: begin
          if (out_ready) begin
            st   <= ST_RUN;
            pc_q <= pc_inc;
          end
        end
        default: st <= ST_RUN;
      endcase
    end
  end

  a_r4_single_start: assert property (@(posedge clk) disable iff (!rst_n)
    eng_start |=> (!eng_start && busy));
  a_r3_wait_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_RUN && op == OP_WAIT && !met) |=> (pc == $past(pc)));
  a_r8_jump_target: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_RUN && op == OP_JUMP) |=> (pc == $past(target)));
  a_r5_route_advance: assert property (@(posedge clk) disable iff (!rst_n)
    route_valid |=> (!route_valid && pc == $past(pc) + PC_ONE));
  a_r6_out_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(pc)));
  a_r10_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_RUN && op != OP_FIR) |=> !busy);
endmodule

// File: rtl/fchain_seq.sv
module fchain_seq
  import fcs_pkg::*;
#(
  parameter int PC_W  = 3,
  parameter int CNT_W = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  in_valid,
  output logic                  in_ready,
  output logic [PC_W-1:0]       pm_addr,
  input  logic [INSTR_W-1:0]    pm_data,
  output logic                  eng_start,
  output logic [CFG_W-1:0]      eng_cfg,
  input  logic                  eng_done,
  output logic                  route_valid,
  output logic [PC_W-1:0]       route_step,
  output logic                  out_valid,
  input  logic                  out_ready
);
  op_e              dec_op;
  logic             dec_rst;
  logic             dec_out;
  logic [PC_W-1:0]  dec_dest;
  logic [PC_W-1:0]  dec_target;
  logic [CNT_W-1:0] dec_need;
  logic [CFG_W-1:0] dec_cfg;
  logic             met;
  logic             wait_clr;
  logic             busy;
  logic [CFG_W-1:0] cfg_q;

  fcs_decode #(.PC_W(PC_W), .CNT_W(CNT_W)) u_dec (
    .word(pm_data), .op(dec_op), .rst_wait(dec_rst), .to_out(dec_out),
    .dest(dec_dest), .target(dec_target), .need(dec_need), .cfg(dec_cfg)
  );

  fcs_wait_ctr #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .clr(wait_clr), .need(dec_need), .met(met)
  );

  fcs_ctrl #(.PC_W(PC_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .op(dec_op), .met(met), .rst_wait(dec_rst),
    .to_out(dec_out), .dest(dec_dest), .target(dec_target),
    .eng_done(eng_done), .out_ready(out_ready), .pc(pm_addr),
    .eng_start(eng_start), .busy(busy), .route_valid(route_valid),
    .route_step(route_step), .out_valid(out_valid), .wait_clr(wait_clr)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)         cfg_q <= '0;
    else if (eng_start) cfg_q <= dec_cfg;
  end

  always_comb eng_cfg = eng_start ? dec_cfg : cfg_q;

  a_r4_cfg_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(eng_cfg));
  a_r6_no_emit_on_route: assert property (@(posedge clk) disable iff (!rst_n)
    route_valid |-> !out_valid);
endmodule

// File: tb/fchain_seq_bench.sv
module fchain_seq_bench;
  import fcs_pkg::*;

  localparam int PC_W  = 3;
  localparam int CNT_W = 4;

  logic                 clk = 1'b0;
  logic                 rst_n = 1'b0;
  logic                 in_valid = 1'b0;
  logic                 in_ready;
  logic [PC_W-1:0]      pm_addr;
  logic [INSTR_W-1:0]   pm_data;
  logic                 eng_start;
  logic [CFG_W-1:0]     eng_cfg;
  logic                 eng_done = 1'b0;
  logic                 route_valid;
  logic [PC_W-1:0]      route_step;
  logic                 out_valid;
  logic                 out_ready = 1'b0;

  logic [INSTR_W-1:0]   prog [8];
  int checks = 0;
  int failures = 0;

  always #2.5 clk = ~clk;
  always_comb pm_data = prog[pm_addr];

  fchain_seq #(.PC_W(PC_W), .CNT_W(CNT_W)) u_fchain_seq (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .pm_addr(pm_addr), .pm_data(pm_data), .eng_start(eng_start),
    .eng_cfg(eng_cfg), .eng_done(eng_done), .route_valid(route_valid),
    .route_step(route_step), .out_valid(out_valid), .out_ready(out_ready)
  );

  function automatic logic [INSTR_W-1:0] mk_wait(int n);
    return {2'b00, 38'(n)};
  endfunction
  function automatic logic [INSTR_W-1:0] mk_jump(int t);
    return {2'b10, 38'(t)};
  endfunction
  function automatic logic [INSTR_W-1:0] mk_rsv();
    return {2'b11, 38'd0};
  endfunction
  function automatic logic [INSTR_W-1:0] mk_fir(bit clr, bit to_out, int dst,
                                                logic [CFG_W-1:0] cfg);
    return {2'b01, clr, to_out, 3'(dst), cfg};
  endfunction

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0; in_valid = 1'b0; eng_done = 1'b0; out_ready = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic strobe();
    in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic t_reset();
    for (int i = 0; i < 8; i++) prog[i] = mk_wait(2);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1 pm_addr in reset", 64'(pm_addr), 0);
    chk("R1 outputs low in reset", {eng_start, route_valid, out_valid}, 0);
    chk("R1 in_ready in reset", 64'(in_ready), 1);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 pm_addr after reset", 64'(pm_addr), 0);
  endtask

  task automatic t_chain();
    logic [CFG_W-1:0] cfg_a = 33'h1_2345_6789;
    logic [CFG_W-1:0] cfg_b = 33'h0_0F0F_A5A5;
    prog[0] = mk_wait(2);
    prog[1] = mk_fir(1'b1, 1'b0, 2, cfg_a);
    prog[2] = mk_fir(1'b0, 1'b1, 0, cfg_b);
    prog[3] = mk_jump(0);
    for (int i = 4; i < 8; i++) prog[i] = mk_rsv();
    do_reset();
    repeat (3) @(negedge clk);
    chk("R3 wait holds with no samples", 64'(pm_addr), 0);
    strobe();
    @(negedge clk);
    chk("R3 wait holds at count 1", 64'(pm_addr), 0);
    strobe();
    @(negedge clk);
    chk("R3 wait advances at count 2", 64'(pm_addr), 1);
    chk("R4 start pulse", 64'(eng_start), 1);
    chk("R4 cfg at start", 64'(eng_cfg), 64'(cfg_a));
    @(negedge clk);
    chk("R4 start one cycle", 64'(eng_start), 0);
    chk("R4 cfg held while busy", 64'(eng_cfg), 64'(cfg_a));
    begin
      int extra = 0;
      for (int i = 0; i < 3; i++) begin
        @(negedge clk);
        if (eng_start) extra++;
      end
      chk("R4 no restart before done", 64'(extra), 0);
    end
    eng_done = 1'b1;
    #1;
    chk("R5 route strobe", {route_valid, out_valid}, 2'b10);
    chk("R5 route destination", 64'(route_step), 2);
    @(negedge clk);
    eng_done = 1'b0;
    chk("R5 advance after route", 64'(pm_addr), 2);
    chk("R4 second filter starts", 64'(eng_start), 1);
    chk("R4 cfg of second filter", 64'(eng_cfg), 64'(cfg_b));
    @(negedge clk);
    eng_done = 1'b1;
    #1;
    chk("R6 no route for output step", 64'(route_valid), 0);
    @(negedge clk);
    eng_done = 1'b0;
    chk("R6 out_valid raised", 64'(out_valid), 1);
    @(negedge clk);
    chk("R6 out_valid held under back-pressure", {out_valid, pm_addr}, {1'b1, 3'd2});
    out_ready = 1'b1;
    @(negedge clk);
    out_ready = 1'b0;
    chk("R6 released after accept", {out_valid, pm_addr}, {1'b0, 3'd3});
    @(negedge clk);
    chk("R8 jump to step 0", 64'(pm_addr), 0);
    repeat (3) @(negedge clk);
    chk("R7 counter cleared, wait holds", 64'(pm_addr), 0);
    strobe();
    @(negedge clk);
    chk("R7 one fresh sample not enough", 64'(pm_addr), 0);
    strobe();
    @(negedge clk);
    chk("R7 two fresh samples pass wait", 64'(pm_addr), 1);
    eng_done = 1'b1;
    @(negedge clk);
    eng_done = 1'b0;
  endtask

  task automatic t_saturate();
    prog[0] = mk_wait(15);
    prog[1] = mk_fir(1'b1, 1'b0, 0, 33'h0_0000_0011);
    prog[2] = mk_jump(2);
    do_reset();
    in_valid = 1'b1;
    repeat (20) @(negedge clk);
    chk("R2 in_ready low when full", 64'(in_ready), 0);
    chk("R3 wait of 15 passed", 64'(pm_addr), 1);
    repeat (3) @(negedge clk);
    chk("R2 stays full under offers", 64'(in_ready), 0);
    eng_done = 1'b1;
    @(negedge clk);
    eng_done = 1'b0;
    chk("R7 clear reopens in_ready", 64'(in_ready), 1);
    chk("R5 advance after route", 64'(pm_addr), 2);
    @(negedge clk);
    in_valid = 1'b0;
    @(negedge clk);
    chk("R8 self jump stays", 64'(pm_addr), 2);
  endtask

  task automatic t_wrap();
    for (int i = 0; i < 8; i++) prog[i] = mk_rsv();
    do_reset();
    eng_done = 1'b1;
    out_ready = 1'b1;
    begin
      int bad_pc = 0;
      int bad_out = 0;
      for (int k = 1; k <= 10; k++) begin
        @(negedge clk);
        if (pm_addr != 3'(k % 8)) bad_pc++;
        if (eng_start || route_valid || out_valid) bad_out++;
      end
      chk("R9 R11 reserved steps advance and wrap", 64'(bad_pc), 0);
      chk("R10 stray done has no effect", 64'(bad_out), 0);
    end
    eng_done = 1'b0;
    out_ready = 1'b0;
  endtask

  bit finished = 1'b0;

  initial begin
    t_reset();
    t_chain();
    t_saturate();
    t_wrap();
    if (!finished) begin
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      failures++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule